// File: doc/BRIEF.md
# Fractional-Rate Hardware Time Counter

This block keeps a free-running nanosecond count for a precision-time clock. Each cycle in which the reference tick input is high is one step of 8 ns. A 32-bit fraction accumulator sits below the nanosecond count. It takes a signed sub-nanosecond correction on every step, so the average rate can be trimmed up or down in units of 2^-32 ns per tick. The nanosecond count is 40 bits wide and wraps modulo 2^40, roughly every 18 minutes.

Software reaches the counter through a 32-bit word interface with a one-cycle read latency. Reading the fraction word takes a snapshot of the whole time value. Later reads of the two nanosecond words return that snapshot, so a multi-word read is coherent. Writes go through a two-state staging machine. In state WS_IDLE, a write of the low nanosecond word stores the word and moves to WS_HELD. In WS_HELD, another low-word write replaces the stored word and the state stays WS_HELD. A high-word write in WS_HELD commits both words together, clears the fraction and returns to WS_IDLE. A halt bit in the control word freezes the count. The halt bit is set out of reset.

Top module: `tc_core`

## Requirements
- R1: After reset the time and fraction are zero, the rate word is zero and the control word (address 4) reads 0x8000_0000, meaning halted.
- R2: With the halt bit clear and a zero rate magnitude, each cycle with tick_i high adds exactly 8 to the nanosecond count.
- R3: While control bit 31 is 1, ticks leave the nanosecond count and the fraction unchanged. Writing 0 to address 4 clears the bit.
- R4: With rate word (address 3) bit 31 = 0, each tick adds bits 30:0 to the fraction. A carry out of the 32-bit fraction adds one extra nanosecond on that tick.
- R5: With rate word bit 31 = 1, each tick subtracts bits 30:0 from the fraction. A borrow removes one nanosecond from that tick's step.
- R6: The nanosecond count wraps modulo 2^40. The high nanosecond word (address 2) carries bits 39:32 in its bits 7:0, and its bits 31:8 read as zero.
- R7: A read of the fraction word (address 0) returns the live fraction and latches the live nanosecond count. Reads of addresses 1 and 2 return the latched value until the next read of address 0.
- R8: A write to address 1 changes nothing visible. A following write to address 2 sets the count to {wdata[7:0], stored low word} and clears the fraction, both in the same cycle.
- R9: If a commit and a tick fall in the same cycle, the result is the committed value plus one full step computed from a zero fraction.
- R10: A write to address 2 while no low word is stored has no effect, and a write to address 0 has no effect.
- R11: rdata_o shows the addressed word in the cycle after rd_en_i, and otherwise holds its last value. Addresses 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One 8 ns time step when high |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 3 | Word address: 0 fraction, 1 ns low, 2 ns high, 3 rate, 4 control |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |

## Verification
The count itself is not visible outside the block, so a wrong internal state shows up only through a read. A fraction that drifts or a lost carry appears as a nanosecond value off by one after the wrapping tick. A stuck or early snapshot appears as a low word that does not match the fraction read just before it. A staging machine left in the wrong state shows a commit that happens too early or not at all. A behavioural model in the bench follows every clock and compares rdata_o in each cycle, so any such fault is reported at the first read that follows it.

// File: rtl/tc_pkg.sv
package tc_pkg;
    typedef enum logic [2:0] {
        REG_SUBNS = 3'd0,
        REG_NS_LO = 3'd1,
        REG_NS_HI = 3'd2,
        REG_RATE  = 3'd3,
        REG_CTRL  = 3'd4
    } reg_sel_e;

    typedef enum logic {
        WS_IDLE = 1'b0,
        WS_HELD = 1'b1
    } wstage_e;
endpackage

// File: rtl/tc_step_unit.sv
module tc_step_unit #(
    parameter int NS_W    = 40,
    parameter int FRAC_W  = 32,
    parameter int STEP_NS = 8
) (
    input  logic [NS_W-1:0]   ns_in,
    input  logic [FRAC_W-1:0] frac_in,
    input  logic [FRAC_W-1:0] rate_in,
    output logic [NS_W-1:0]   ns_out,
    output logic [FRAC_W-1:0] frac_out
);
    localparam logic [NS_W-1:0] STEP_V = NS_W'(STEP_NS);

    logic [FRAC_W:0] mag_ext;
    logic [FRAC_W:0] sum_ext;
    logic [FRAC_W:0] dif_ext;
    logic            subtract;
    logic [NS_W-1:0] bump;

    always_comb begin
        subtract = rate_in[FRAC_W-1];
        mag_ext  = {2'b00, rate_in[FRAC_W-2:0]};
        sum_ext  = {1'b0, frac_in} + mag_ext;
        dif_ext  = {1'b0, frac_in} - mag_ext;
        if (subtract) begin
            frac_out = dif_ext[FRAC_W-1:0];
            bump     = STEP_V - NS_W'(dif_ext[FRAC_W]);
        end else begin
            frac_out = sum_ext[FRAC_W-1:0];
            bump     = STEP_V + NS_W'(sum_ext[FRAC_W]);
        end
        ns_out = ns_in + bump;
    end
endmodule

// File: rtl/tc_write_stage.sv
module tc_write_stage
    import tc_pkg::*;
#(
    parameter int NS_W   = 40,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              commit,
    output logic [NS_W-1:0]   commit_ns
);
    localparam int HI_W = NS_W - DATA_W;

    wstage_e           state_q, state_d;
    logic [DATA_W-1:0] lo_q;
    logic              wr_lo, wr_hi;

    assign wr_lo = wr_en && (addr == REG_NS_LO);
    assign wr_hi = wr_en && (addr == REG_NS_HI);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
            lo_q    <= '0;
        end else begin
            state_q <= state_d;
            if (wr_lo) lo_q <= wdata;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE: if (wr_lo) state_d = WS_HELD;
            WS_HELD: if (wr_hi && !wr_lo) state_d = WS_IDLE;
            default: state_d = WS_IDLE;
        endcase
    end

    always_comb begin
        commit    = 1'b0;
        commit_ns = {wdata[HI_W-1:0], lo_q};
        unique case (state_q)
            WS_IDLE: commit = 1'b0;
            WS_HELD: commit = wr_hi;
            default: commit = 1'b0;
        endcase
    end

    AST_COMMIT_RETURNS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (state_q == WS_IDLE)); // R8
    AST_LO_WRITE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (state_q == WS_HELD && lo_q == $past(wdata))); // R8
endmodule

// File: rtl/tc_snapshot.sv
module tc_snapshot #(
    parameter int NS_W = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic [NS_W-1:0] ns_live,
    output logic [NS_W-1:0] snap_ns
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       snap_ns <= '0;
        else if (capture) snap_ns <= ns_live;
    end

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(snap_ns)); // R7
endmodule

// File: rtl/tc_core.sv
module tc_core
    import tc_pkg::*;
#(
    parameter int NS_W    = 40,
    parameter int DATA_W  = 32,
    parameter int STEP_NS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [2:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int FRAC_W = DATA_W;
    localparam int HI_W   = NS_W - DATA_W;

    logic [NS_W-1:0]   ns_q;
    logic [FRAC_W-1:0] frac_q;
    logic [DATA_W-1:0] rate_q;
    logic              halt_q;
    logic              commit;
    logic [NS_W-1:0]   commit_ns;
    logic [NS_W-1:0]   base_ns, next_ns, snap_ns;
    logic [FRAC_W-1:0] base_frac, next_frac;
    logic              advance, snap_take;
    logic [DATA_W-1:0] rd_mux;

    tc_write_stage #(.NS_W(NS_W), .DATA_W(DATA_W)) u_wstage (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .addr(addr_i),
        .wdata(wdata_i), .commit(commit), .commit_ns(commit_ns)
    );

    assign base_ns   = commit ? commit_ns : ns_q;
    assign base_frac = commit ? '0 : frac_q;
    assign advance   = tick_i && !halt_q;

    tc_step_unit #(.NS_W(NS_W), .FRAC_W(FRAC_W), .STEP_NS(STEP_NS)) u_step (
        .ns_in(base_ns), .frac_in(base_frac), .rate_in(rate_q),
        .ns_out(next_ns), .frac_out(next_frac)
    );

    assign snap_take = rd_en_i && (addr_i == REG_SUBNS);

    tc_snapshot #(.NS_W(NS_W)) u_snap (
        .clk(clk), .rst_n(rst_n), .capture(snap_take),
        .ns_live(ns_q), .snap_ns(snap_ns)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ns_q   <= '0;
            frac_q <= '0;
        end else if (advance) begin
            ns_q   <= next_ns;
            frac_q <= next_frac;
        end else if (commit) begin
            ns_q   <= commit_ns;
            frac_q <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_q <= '0;
            halt_q <= 1'b1;
        end else if (wr_en_i) begin
            if (addr_i == REG_RATE) rate_q <= wdata_i;
            if (addr_i == REG_CTRL) halt_q <= wdata_i[DATA_W-1];
        end
    end

    always_comb begin
        case (addr_i)
            REG_SUBNS: rd_mux = frac_q;
            REG_NS_LO: rd_mux = snap_ns[DATA_W-1:0];
            REG_NS_HI: rd_mux = {{(DATA_W-HI_W){1'b0}}, snap_ns[NS_W-1:DATA_W]};
            REG_RATE:  rd_mux = rate_q;
            REG_CTRL:  rd_mux = {halt_q, {(DATA_W-1){1'b0}}};
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rdata_o <= '0;
        else if (rd_en_i) rdata_o <= rd_mux;
    end

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !commit) |=> (((ns_q - $past(ns_q)) >= NS_W'(STEP_NS-1)) &&
                                  ((ns_q - $past(ns_q)) <= NS_W'(STEP_NS+1)))); // R2
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_q && !commit) |=> ($stable(ns_q) && $stable(frac_q))); // R3
    AST_POS_NO_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !commit && !rate_q[DATA_W-1]) |=> ((ns_q - $past(ns_q)) >= NS_W'(STEP_NS))); // R4
    AST_NEG_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !commit && rate_q[DATA_W-1]) |=> ((ns_q - $past(ns_q)) <= NS_W'(STEP_NS))); // R5
    AST_HI_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == REG_NS_HI) |=> (rdata_o[DATA_W-1:HI_W] == '0)); // R6
    AST_COMMIT_FRAC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !advance) |=> (frac_q == '0 && ns_q == $past(commit_ns))); // R8
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rdata_o)); // R11
endmodule

// File: tb/tb_tc_core.sv
module tb_tc_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        rd_en_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  addr_i = 3'd0;
    logic [31:0] wdata_i = 32'd0;
    logic [31:0] rdata_o;

    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    tc_core dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rd_en_i(rd_en_i),
        .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
    );

    // behavioural reference model
    longint m_ns = 0, m_frac = 0, m_snap = 0, m_lo = 0;
    longint m_rate = 0;
    bit     m_halt = 1, m_held = 0;
    longint m_rdata = 0;
    localparam longint TWO32 = 64'h1_0000_0000;
    localparam longint MASK40 = 64'hFF_FFFF_FFFF;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ns = 0; m_frac = 0; m_snap = 0; m_lo = 0; m_rate = 0;
            m_halt = 1; m_held = 0; m_rdata = 0;
        end else begin
            longint b_ns, b_frac, f, mag, st;
            bit cm;
            if (rd_en_i) begin
                case (addr_i)
                    3'd0: begin m_rdata = m_frac; m_snap = m_ns; end
                    3'd1: m_rdata = m_snap & 64'hFFFF_FFFF;
                    3'd2: m_rdata = (m_snap >> 32) & 64'hFF;
                    3'd3: m_rdata = m_rate;
                    3'd4: m_rdata = m_halt ? 64'h8000_0000 : 0;
                    default: m_rdata = 0;
                endcase
            end
            cm = wr_en_i && addr_i == 3'd2 && m_held;
            b_ns = cm ? ((longint'(wdata_i[7:0]) << 32) | m_lo) : m_ns;
            b_frac = cm ? 0 : m_frac;
            if (tick_i && !m_halt) begin
                mag = m_rate & 64'h7FFF_FFFF;
                st = 8;
                if (m_rate & 64'h8000_0000) begin
                    f = b_frac - mag;
                    if (f < 0) begin f = f + TWO32; st = 7; end
                end else begin
                    f = b_frac + mag;
                    if (f >= TWO32) begin f = f - TWO32; st = 9; end
                end
                m_ns = (b_ns + st) & MASK40;
                m_frac = f;
            end else begin
                m_ns = b_ns; m_frac = b_frac;
            end
            if (wr_en_i) begin
                if (addr_i == 3'd1) begin m_held = 1; m_lo = wdata_i; end
                else if (addr_i == 3'd2) m_held = 0;
                if (addr_i == 3'd3) m_rate = wdata_i;
                if (addr_i == 3'd4) m_halt = wdata_i[31];
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            n_chk++;
            if (rdata_o !== m_rdata[31:0]) begin
                n_fail++;
                $display("FAIL R11 per-cycle rdata actual=%h expected=%h", rdata_o, m_rdata[31:0]);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk); wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk); rd_en_i = 1'b1; addr_i = a;
        @(negedge clk); rd_en_i = 1'b0; v = rdata_o;
    endtask

    task automatic ticks(input int n);
        @(negedge clk); tick_i = 1'b1;
        repeat (n) @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic set_time(input logic [31:0] hi, input logic [31:0] lo);
        wr(3'd1, lo);
        wr(3'd2, hi);
    endtask

    task automatic expect_time(input string tag, input logic [31:0] fr,
                               input logic [31:0] lo, input logic [31:0] hi);
        logic [31:0] v;
        rd(3'd0, v); chk({tag, " fraction"}, v, fr);
        rd(3'd1, v); chk({tag, " ns low"}, v, lo);
        rd(3'd2, v); chk({tag, " ns high"}, v, hi);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        rd(3'd4, v); chk("R1 control after reset", v, 32'h8000_0000);
        rd(3'd3, v); chk("R1 rate after reset", v, 32'h0);
        expect_time("R1 reset time", 0, 0, 0);

        ticks(5);
        expect_time("R3 halted ticks", 0, 0, 0);

        wr(3'd4, 32'h0);
        rd(3'd4, v); chk("R3 control cleared", v, 32'h0);
        set_time(0, 100);
        expect_time("R8 commit", 0, 100, 0);
        ticks(10);
        expect_time("R2 ten nominal steps", 0, 180, 0);

        wr(3'd2, 32'h5);
        wr(3'd0, 32'h1234);
        expect_time("R10 orphan high and fraction writes", 0, 180, 0);

        wr(3'd1, 1000);
        expect_time("R8 low word staged only", 0, 180, 0);
        wr(3'd2, 0);
        expect_time("R8 staged commit", 0, 1000, 0);

        wr(3'd3, 32'h4000_0000);
        set_time(0, 0);
        ticks(3);
        expect_time("R4 positive before carry", 32'hC000_0000, 24, 0);
        ticks(1);
        expect_time("R4 positive carry", 0, 33, 0);

        wr(3'd3, 32'hC000_0000);
        set_time(0, 1000);
        ticks(1);
        expect_time("R5 negative borrow", 32'hC000_0000, 1007, 0);
        ticks(3);
        expect_time("R5 negative four ticks", 0, 1031, 0);

        wr(3'd3, 32'h0);
        set_time(32'hABCD_EFFF, 32'hFFFF_FFF8);
        expect_time("R6 top of range", 0, 32'hFFFF_FFF8, 32'h0000_00FF);
        ticks(1);
        expect_time("R6 wrap", 0, 0, 0);

        set_time(0, 500);
        rd(3'd0, v);
        ticks(4);
        rd(3'd1, v); chk("R7 snapshot low held", v, 500);
        rd(3'd2, v); chk("R7 snapshot high held", v, 0);
        rd(3'd0, v);
        rd(3'd1, v); chk("R7 snapshot refreshed", v, 532);

        wr(3'd1, 2000);
        @(negedge clk); wr_en_i = 1'b1; addr_i = 3'd2; wdata_i = 0; tick_i = 1'b1;
        @(negedge clk); wr_en_i = 1'b0; tick_i = 1'b0;
        expect_time("R9 commit with tick", 0, 2008, 0);

        wr(3'd4, 32'h8000_0000);
        ticks(5);
        expect_time("R3 halted again", 0, 2008, 0);
        rd(3'd6, v); chk("R11 unmapped address", v, 0);

        wr(3'd4, 32'h0);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            tick_i  = ($urandom_range(0, 3) != 0);
            rd_en_i = ($urandom_range(0, 2) == 0);
            wr_en_i = ($urandom_range(0, 5) == 0);
            addr_i  = 3'($urandom_range(0, 5));
            wdata_i = $urandom;
            if (wr_en_i && addr_i == 3'd4) wdata_i[31] = ($urandom_range(0, 3) == 0);
        end
        @(negedge clk);
        tick_i = 1'b0; rd_en_i = 1'b0; wr_en_i = 1'b0;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule